// File: doc/BRIEF.md
# Multichannel Interrupt Multiplexer

This block fans a bank of active-high level interrupt lines out to several independent output channels. Every source reaches every channel. Each channel holds its own enable mask, so any source can be steered to any subset of the outputs by setting the matching bit in the masks of the wanted channels. A channel's output is high while at least one of its unmasked sources is high. It falls once those sources drop.

Sources are brought into the clock domain through a two-flop synchroniser. Software programs the masks through a single-cycle memory-mapped register port. The port has byte address, write enable, write data and registered read data. Per channel there is a readable and writable enable word and a read-only pending word. The pending word shows which unmasked sources are currently active, so a handler can scan it and service each set bit.

Top module: `irq_router`

## Requirements
- R1: There are 8 channels, each with one output bit `irq_o[n]`. All 32 sources feed every channel, and bit k of any channel register refers to source k.
- R2: Channel n's enable word sits at byte address 0x10 + 0x40·n. All 32 bits are writable and read back exactly as written.
- R3: Channel n's pending word sits at byte address 0x20 + 0x40·n. It reads as the synchronised source levels ANDed with channel n's enable word. Writes to it change neither it nor any enable word.
- R4: `irq_o[n]` is high exactly when channel n has a pending bit set. It stays high while an enabled source stays high, and it returns low after the source drops.
- R5: A source change appears on `irq_o` at the third rising clock edge after it is applied: two synchroniser flops followed by the output register.
- R6: A write to one channel's enable word leaves every other channel's enable word unchanged.
- R7: After reset, all enable words are zero, every `irq_o` bit is low and `rd_data_o` is zero.
- R8: A read of any other address returns zero, and a write to it has no effect. This includes misaligned offsets such as 0x14 and 0x30.
- R9: Read data is registered. `rd_data_o` shows the word addressed in the previous cycle and does not change before the next rising edge.
- R10: A change to an enable word reaches `irq_o` at the second rising edge counted from the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | Register byte address |
| wr_en_i | input | 1 | Write strobe, sampled at the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| src_i | input | 32 | Asynchronous level interrupt sources |
| irq_o | output | 8 | Per-channel interrupt outputs |

## Verification
The bench builds the block with its default parameters: 8 channels, 32 sources and a 10-bit address. This puts the highest-placed registers, at 0x1D0 and 0x1E0, inside the decoded range, so the address stride is checked up to the last channel. Because all 32 source bits are present, the top and bottom bits of every mask are checked as well. Distinct mask patterns per channel make any cross-channel write or read-mux mix-up show up as a wrong word. Misaligned offsets inside a channel's window check that the decode matches full addresses only.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned EN_BASE   = 'h10;
  localparam int unsigned PEND_BASE = 'h20;
  localparam int unsigned CH_STRIDE = 'h40;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/irq_chan.sv
module irq_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_sync_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] en_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wr_data_i;
  end

  assign pend_o = src_sync_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_o;
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  AST_MASKED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !irq_o); // R4
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|src_sync_i)); // R4
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q)); // R6
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_en_i,
  input  logic [N_CH-1:0][W-1:0]  en_rd_i,
  input  logic [N_CH-1:0][W-1:0]  pend_rd_i,
  output logic [N_CH-1:0]         wr_sel_o,
  output logic [W-1:0]            rd_data_o
);
  logic [N_CH-1:0] en_hit, pend_hit;
  logic            hit_any;
  logic [W-1:0]    rd_next, rd_q;

  always_comb begin
    en_hit   = '0;
    pend_hit = '0;
    rd_next  = '0;
    for (int n = 0; n < N_CH; n++) begin
      en_hit[n]   = (addr_i == ADDR_W'(EN_BASE   + CH_STRIDE * n));
      pend_hit[n] = (addr_i == ADDR_W'(PEND_BASE + CH_STRIDE * n));
      rd_next     = rd_next | ({W{en_hit[n]}} & en_rd_i[n])
                            | ({W{pend_hit[n]}} & pend_rd_i[n]);
    end
  end

  assign hit_any  = |{en_hit, pend_hit};
  assign wr_sel_o = en_hit & {N_CH{wr_en_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_any |=> (rd_data_o == '0)); // R8
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [N_SRC-1:0]  wr_data_i,
  output logic [N_SRC-1:0]  rd_data_o,
  input  logic [N_SRC-1:0]  src_i,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_SRC-1:0]            src_sync;
  logic [N_CH-1:0]             wr_sel;
  logic [N_CH-1:0][N_SRC-1:0]  en_rd, pend_rd;

  irq_src_sync #(.W(N_SRC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (src_i),
    .sync_o  (src_sync)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    irq_chan #(.W(N_SRC)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_sync_i (src_sync),
      .wr_i       (wr_sel[n]),
      .wr_data_i  (wr_data_i),
      .en_o       (en_rd[n]),
      .pend_o     (pend_rd[n]),
      .irq_o      (irq_o[n])
    );
  end

  irq_reg_decode #(.N_CH(N_CH), .W(N_SRC), .ADDR_W(ADDR_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .en_rd_i   (en_rd),
    .pend_rd_i (pend_rd),
    .wr_sel_o  (wr_sel),
    .rd_data_o (rd_data_o)
  );

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (wr_sel == '0)); // R6
endmodule

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int N_CH = 8;
  localparam logic [9:0] IDLE_A = 10'h3FC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = IDLE_A;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic [31:0] src = '0;
  logic [7:0]  irq;
  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wd), .rd_data_o(rd), .src_i(src), .irq_o(irq)
  );

  function automatic logic [9:0] en_a(int n);   return 10'(16 + 64 * n); endfunction
  function automatic logic [9:0] pend_a(int n); return 10'(32 + 64 * n); endfunction
  function automatic logic [31:0] pat(int n);
    return 32'h8137_9BD1 ^ (32'(n) * 32'h0101_0101) ^ (32'h1 << n);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0; addr = IDLE_A;
  endtask

  task automatic rdw(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rd; addr = IDLE_A;
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk); src = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R7 rd_data", rd, 32'h0);
    chk("R7 irq", {24'h0, irq}, 32'h0);
    rdw(en_a(0), d); chk("R7 en ch0", d, 32'h0);
    rdw(en_a(7), d); chk("R7 en ch7", d, 32'h0);
  endtask

  task automatic t_rw_enable;
    logic [31:0] d;
    for (int n = 0; n < N_CH; n++) wr(en_a(n), pat(n));
    for (int n = 0; n < N_CH; n++) begin
      rdw(en_a(n), d); chk($sformatf("R2 en ch%0d", n), d, pat(n));
      rdw(pend_a(n), d); chk($sformatf("R3 pend idle ch%0d", n), d, 32'h0);
    end
  endtask

  task automatic t_route;
    logic [31:0] d;
    set_src(32'hFFFF_FFFF);
    chk("R1 all irq", {24'h0, irq}, 32'hFF);
    for (int n = 0; n < N_CH; n++) begin
      rdw(pend_a(n), d); chk($sformatf("R3 pend ch%0d", n), d, pat(n));
    end
    set_src(32'h0000_F00F);
    for (int n = 0; n < N_CH; n++) begin
      rdw(pend_a(n), d); chk($sformatf("R3 pend mix ch%0d", n), d, pat(n) & 32'h0000_F00F);
    end
    for (int n = 0; n < N_CH; n++) wr(en_a(n), 32'h0);
    wr(en_a(3), 32'h20);
    set_src(32'h20);
    chk("R1 route src5 ch3", {24'h0, irq}, 32'h08);
    wr(en_a(6), 32'h20);
    @(negedge clk);
    chk("R1 route src5 ch3+ch6", {24'h0, irq}, 32'h48);
    set_src(32'h40);
    chk("R4 other src masked", {24'h0, irq}, 32'h0);
  endtask

  task automatic t_pend_wr;
    logic [31:0] d;
    wr(en_a(2), 32'h8000_0001);
    set_src(32'h8000_0003);
    wr(pend_a(2), 32'hFFFF_FFFF);
    rdw(pend_a(2), d); chk("R3 pend after write", d, 32'h8000_0001);
    rdw(en_a(2), d);   chk("R3 en after pend write", d, 32'h8000_0001);
    rdw(en_a(1), d);   chk("R3 neighbour en", d, 32'h0);
  endtask

  task automatic t_level;
    set_src(32'h0);
    chk("R4 low after drop", {24'h0, irq}, 32'h0);
    @(negedge clk); src = 32'h8000_0000;
    @(negedge clk); chk("R5 edge1", {24'h0, irq}, 32'h0);
    @(negedge clk); chk("R5 edge2", {24'h0, irq}, 32'h0);
    @(negedge clk); chk("R5 edge3", {24'h0, irq}, 32'h04);
    repeat (5) @(negedge clk);
    chk("R4 held", {24'h0, irq}, 32'h04);
    src = 32'h0;
    @(negedge clk); @(negedge clk);
    chk("R5 fall edge2", {24'h0, irq}, 32'h04);
    @(negedge clk);
    chk("R4 fall", {24'h0, irq}, 32'h0);
  endtask

  task automatic t_en_latency;
    set_src(32'h0000_0100);
    @(negedge clk); addr = en_a(7); we = 1'b1; wd = 32'h100;
    @(negedge clk); we = 1'b0; addr = IDLE_A;
    chk("R10 edge1", {24'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 edge2", {24'h0, irq}, 32'h80);
  endtask

  task automatic t_isolation;
    logic [31:0] d;
    for (int n = 0; n < N_CH; n++) wr(en_a(n), pat(n));
    wr(en_a(4), 32'h0F0F_0F0F);
    for (int n = 0; n < N_CH; n++) begin
      rdw(en_a(n), d);
      chk($sformatf("R6 ch%0d", n), d, (n == 4) ? 32'h0F0F_0F0F : pat(n));
    end
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [7:0]  irq_before;
    rdw(10'h000, d); chk("R8 rd 0x00", d, 32'h0);
    rdw(10'h014, d); chk("R8 rd 0x14", d, 32'h0);
    rdw(10'h030, d); chk("R8 rd 0x30", d, 32'h0);
    rdw(10'h200, d); chk("R8 rd 0x200", d, 32'h0);
    set_src(32'hFFFF_FFFF);
    irq_before = irq;
    wr(10'h014, 32'h0); wr(10'h011, 32'h0); wr(10'h3D0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R8 irq unchanged", {24'h0, irq}, {24'h0, irq_before});
    rdw(en_a(0), d); chk("R8 ch0 en kept", d, pat(0));
    rdw(en_a(7), d); chk("R8 ch7 en kept", d, pat(7));
  endtask

  task automatic t_read_reg;
    @(negedge clk); addr = en_a(5);
    #1 chk("R9 before edge", rd, 32'h0);
    @(negedge clk); chk("R9 after edge", rd, pat(5));
    addr = en_a(1);
    #1 chk("R9 held", rd, pat(5));
    @(negedge clk); chk("R9 next", rd, pat(1));
    addr = IDLE_A;
  endtask

  initial begin
    #(200000 * 5);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw_enable();
    t_route();
    t_pend_wr();
    t_level();
    t_en_latency();
    t_isolation();
    t_unmapped();
    set_src(32'h0);
    t_read_reg();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule